// File: doc/BRIEF.md
# Trace Line Fill Unit

This unit assembles new trace-cache lines after a lookup miss. A miss request hands it the address that missed, and that address becomes the tag of the line under construction. Basic blocks then arrive one at a time on a valid/ready stream. Each block carries its start address, an instruction-word count, a flag telling whether it closes with a branch, that branch's direction, and the branch's target and fall-through addresses. Each block is placed after the instructions already collected. As each branch is placed, one bit of the direction vector and one bit of the internal-branch vector are set.

A fill stops at the first of two limits: `FILL_N` instruction words or `FILL_M` recorded branches. Only at that point are the two exit addresses of the line worked out. If the line closes on a complete block that ends in a branch, the exits are that branch's target and fall-through. Otherwise both exits are the address of the next sequential instruction that did not enter the line.

The finished line is then offered on a second valid/ready stream towards the cache write port. The unit reports itself busy from the accepted miss until that line has been taken. An abort input throws away a fill that is still in progress.

Back-pressure works as follows. A block transfers on a clock edge where `blk_valid` and `blk_ready` are both high. The producer must hold a block's fields steady while it waits. `blk_ready` is high only while a fill is open and `abort` is low. The finished line waits on `line_valid` with all of its fields frozen until the consumer raises `line_ready`.

Top module: `trace_line_fill`

## Requirements
- R1: A `miss_valid` pulse while `busy` is low opens a fill, and `busy` is high from the next cycle. The line tag equals the `miss_addr` captured on that cycle. `miss_valid` has no effect while `busy` is high.
- R2: `blk_ready` is high only while a fill is open (busy, no line pending) and `abort` is low. It is 0 after reset.
- R3: Accepted blocks are appended in order, and `line_len` equals the total number of words taken into the line.
- R4: When a block would take the line past `FILL_N` words, only the words that fit are taken. The fill then ends, and both exit addresses are `blk_addr + taken*INSTR_BYTES`.
- R5: The fill ends when the `FILL_M`-th branch is recorded. The line's target and fall-through are then that block's `blk_target` and `blk_fallthru`.
- R6: `line_flags` bit i holds the direction (1 = taken) of the i-th recorded branch, with bit 0 being the first branch. Bits at and above `line_nbr` are 0.
- R7: `line_mask` has bits 0 to `line_nbr`-2 set and all other bits clear. It is all zero when zero branches or one branch was recorded.
- R8: A branch that closes a block cut short by the word limit is not recorded and does not count toward `line_nbr`.
- R9: A line that reaches exactly `FILL_N` words with a block that has no branch ends with both exits equal to the next sequential address.
- R10: `line_valid` stays high with every line field unchanged until `line_ready`. `busy` is low in the cycle after the line is accepted.
- R11: `abort` during an open fill returns the unit to idle on the next cycle without producing a line. A following fill starts with no words or branches left over. `abort` has no effect while a line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Request to open a fill |
| miss_addr | input | ADDR_W | Missed fetch address, used as the tag |
| busy | output | 1 | Fill open or line pending |
| abort | input | 1 | Discard the fill in progress |
| blk_valid | input | 1 | Block stream valid |
| blk_ready | output | 1 | Block stream ready |
| blk_addr | input | ADDR_W | Address of the block's first word |
| blk_len | input | LEN_W | Word count of the block (at least 1) |
| blk_has_br | input | 1 | Block closes with a branch |
| blk_taken | input | 1 | Direction of that branch, 1 = taken |
| blk_target | input | ADDR_W | Branch target address |
| blk_fallthru | input | ADDR_W | Branch fall-through address |
| line_valid | output | 1 | Finished line offered |
| line_ready | input | 1 | Finished line accepted |
| line_tag | output | ADDR_W | Line tag |
| line_len | output | CNT_W | Words in the line |
| line_nbr | output | NBR_W | Branches recorded |
| line_flags | output | FILL_M | Branch directions |
| line_mask | output | FILL_M | Internal-branch mask |
| line_target | output | ADDR_W | Exit address when the last branch is taken |
| line_fallthru | output | ADDR_W | Exit address when the last branch is not taken |

## Verification
The hardest case to reach is a block that both crosses the word limit and ends in a branch, because the branch has to be dropped while the exits switch to the sequential address. The stimulus table therefore includes lines whose last block is longer than the remaining room and carries a branch. It also includes a single full-length block whose branch lands exactly on the limit, and a line that hits the branch limit with room to spare. Directed sequences then abort after a recorded branch and check that the next fill carries nothing over. They also hold the output stalled while sending a second miss and an abort, both of which must leave the pending line untouched.

// File: rtl/tlf_pkg.sv
`timescale 1ns/1ps
package tlf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_EMIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/tlf_ctrl.sv
`timescale 1ns/1ps
// Sequencing of one fill: idle, collecting blocks, offering the line.
module tlf_ctrl
  import tlf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic abort,
  input  logic blk_valid,
  input  logic fill_done,
  input  logic line_ready,
  output logic start,
  output logic blk_ready,
  output logic blk_fire,
  output logic busy,
  output logic line_valid
);
  fill_state_e state_q, state_d;

  assign start      = (state_q == FS_IDLE) && miss_valid;
  assign blk_ready  = (state_q == FS_FILL) && !abort;
  assign blk_fire   = blk_ready && blk_valid;
  assign busy       = (state_q != FS_IDLE);
  assign line_valid = (state_q == FS_EMIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (miss_valid) state_d = FS_FILL;
      FS_FILL: begin
        if (abort)          state_d = FS_IDLE;
        else if (fill_done) state_d = FS_EMIT;
      end
      FS_EMIT: if (line_ready) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tlf_merge.sv
`timescale 1ns/1ps
// Word accounting: how much of an incoming block fits and where it stops.
module tlf_merge #(
  parameter int ADDR_W      = 32,
  parameter int FILL_N      = 16,
  parameter int LEN_W       = 5,
  parameter int INSTR_BYTES = 4,
  localparam int CNT_W      = $clog2(FILL_N + 1),
  localparam int SW         = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fire,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              whole,
  output logic              done_cnt,
  output logic [ADDR_W-1:0] seq_addr
);
  logic [SW-1:0] room, len_x, take;

  always_comb begin
    room     = SW'(FILL_N) - SW'(cnt);
    len_x    = SW'(blk_len);
    whole    = (len_x <= room);
    take     = whole ? len_x : room;
    done_cnt = ((SW'(cnt) + take) == SW'(FILL_N));
    seq_addr = blk_addr + (ADDR_W'(take) * ADDR_W'(INSTR_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (fire)  cnt <= cnt + CNT_W'(take);
  end
endmodule

// File: rtl/tlf_branch.sv
`timescale 1ns/1ps
// Incremental branch bookkeeping: direction flags and internal-branch mask.
module tlf_branch #(
  parameter int FILL_M = 3,
  localparam int NBR_W = $clog2(FILL_M + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              br_add,
  input  logic              taken,
  output logic [FILL_M-1:0] flags,
  output logic [FILL_M-1:0] mask,
  output logic [NBR_W-1:0]  nbr,
  output logic              done_br
);
  assign done_br = br_add && (nbr == NBR_W'(FILL_M - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nbr <= '0;
    else if (start)  nbr <= '0;
    else if (br_add) nbr <= nbr + 1'b1;
  end

  for (genvar i = 0; i < FILL_M; i++) begin : g_slot
    // Slot i takes the direction of the branch recorded while nbr == i.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flags[i] <= 1'b0;
      else if (start)                            flags[i] <= 1'b0;
      else if (br_add && nbr == NBR_W'(i))       flags[i] <= taken;
    end
    // Slot i becomes internal once a later branch follows it.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mask[i] <= 1'b0;
      else if (start)                            mask[i] <= 1'b0;
      else if (br_add && nbr == NBR_W'(i + 1))   mask[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/tlf_exit.sv
`timescale 1ns/1ps
// Tag capture at start; exit addresses resolved only when the fill closes.
module tlf_exit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              done,
  input  logic              br_exit,
  input  logic [ADDR_W-1:0] blk_target,
  input  logic [ADDR_W-1:0] blk_fallthru,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] tag,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] fallthru
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tag <= '0;
    else if (start) tag <= miss_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target   <= '0;
      fallthru <= '0;
    end else if (done) begin
      target   <= br_exit ? blk_target   : seq_addr;
      fallthru <= br_exit ? blk_fallthru : seq_addr;
    end
  end
endmodule

// File: rtl/trace_line_fill.sv
`timescale 1ns/1ps
module trace_line_fill #(
  parameter int ADDR_W      = 32,
  parameter int FILL_N      = 16,
  parameter int FILL_M      = 3,
  parameter int LEN_W       = 5,
  parameter int INSTR_BYTES = 4,
  localparam int CNT_W      = $clog2(FILL_N + 1),
  localparam int NBR_W      = $clog2(FILL_M + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              busy,
  input  logic              abort,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              blk_has_br,
  input  logic              blk_taken,
  input  logic [ADDR_W-1:0] blk_target,
  input  logic [ADDR_W-1:0] blk_fallthru,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [ADDR_W-1:0] line_tag,
  output logic [CNT_W-1:0]  line_len,
  output logic [NBR_W-1:0]  line_nbr,
  output logic [FILL_M-1:0] line_flags,
  output logic [FILL_M-1:0] line_mask,
  output logic [ADDR_W-1:0] line_target,
  output logic [ADDR_W-1:0] line_fallthru
);
  logic start, blk_fire, fill_done;
  logic whole, done_cnt, done_br, br_add;
  logic [ADDR_W-1:0] seq_addr;

  // A branch counts only if its whole block fits in the line.
  assign br_add    = blk_fire && whole && blk_has_br;
  assign fill_done = blk_fire && (done_cnt || done_br);

  tlf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .abort      (abort),
    .blk_valid  (blk_valid),
    .fill_done  (fill_done),
    .line_ready (line_ready),
    .start      (start),
    .blk_ready  (blk_ready),
    .blk_fire   (blk_fire),
    .busy       (busy),
    .line_valid (line_valid)
  );

  tlf_merge #(
    .ADDR_W      (ADDR_W),
    .FILL_N      (FILL_N),
    .LEN_W       (LEN_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fire     (blk_fire),
    .blk_len  (blk_len),
    .blk_addr (blk_addr),
    .cnt      (line_len),
    .whole    (whole),
    .done_cnt (done_cnt),
    .seq_addr (seq_addr)
  );

  tlf_branch #(
    .FILL_M (FILL_M)
  ) u_branch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .br_add  (br_add),
    .taken   (blk_taken),
    .flags   (line_flags),
    .mask    (line_mask),
    .nbr     (line_nbr),
    .done_br (done_br)
  );

  tlf_exit #(
    .ADDR_W (ADDR_W)
  ) u_exit (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .miss_addr    (miss_addr),
    .done         (fill_done),
    .br_exit      (br_add),
    .blk_target   (blk_target),
    .blk_fallthru (blk_fallthru),
    .seq_addr     (seq_addr),
    .tag          (line_tag),
    .target       (line_target),
    .fallthru     (line_fallthru)
  );
endmodule

// File: rtl/trace_line_fill_chk.sv
`timescale 1ns/1ps
module trace_line_fill_chk #(
  parameter int ADDR_W = 32,
  parameter int FILL_N = 16,
  parameter int FILL_M = 3,
  localparam int CNT_W = $clog2(FILL_N + 1),
  localparam int NBR_W = $clog2(FILL_M + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              busy,
  input logic              abort,
  input logic              blk_ready,
  input logic              line_valid,
  input logic              line_ready,
  input logic [ADDR_W-1:0] line_tag,
  input logic [CNT_W-1:0]  line_len,
  input logic [NBR_W-1:0]  line_nbr,
  input logic [FILL_M-1:0] line_flags,
  input logic [FILL_M-1:0] line_mask,
  input logic [ADDR_W-1:0] line_target,
  input logic [ADDR_W-1:0] line_fallthru
);
  a_r1_open_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && miss_valid) |=> (busy && line_tag == $past(miss_addr)));

  a_r1_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(line_tag));

  a_r2_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> (busy && !line_valid && !abort));

  a_r4_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (line_len <= CNT_W'(FILL_N)));

  a_r5_closed_on_limit: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (line_len == CNT_W'(FILL_N) || line_nbr == NBR_W'(FILL_M)));

  a_r6_flags_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ((line_flags >> line_nbr) == '0));

  a_r7_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ((line_nbr == '0) ? ($countones(line_mask) == 0)
                                     : ($countones(line_mask) == int'(line_nbr) - 1)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_ready) |=> (line_valid && $stable(line_target)
      && $stable(line_fallthru) && $stable(line_len) && $stable(line_flags)
      && $stable(line_mask) && $stable(line_nbr)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_ready) |=> !busy);

  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_valid && abort) |=> (!busy && !line_valid));
endmodule

bind trace_line_fill trace_line_fill_chk #(
  .ADDR_W (ADDR_W),
  .FILL_N (FILL_N),
  .FILL_M (FILL_M)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_addr     (miss_addr),
  .busy          (busy),
  .abort         (abort),
  .blk_ready     (blk_ready),
  .line_valid    (line_valid),
  .line_ready    (line_ready),
  .line_tag      (line_tag),
  .line_len      (line_len),
  .line_nbr      (line_nbr),
  .line_flags    (line_flags),
  .line_mask     (line_mask),
  .line_target   (line_target),
  .line_fallthru (line_fallthru)
);

// File: tb/trace_line_fill_tb_top.sv
`timescale 1ns/1ps
module trace_line_fill_tb_top;
  localparam int ADDR_W = 32;
  localparam int FILL_N = 16;
  localparam int FILL_M = 3;
  localparam int LEN_W  = 5;
  localparam int IB     = 4;
  localparam int CNT_W  = $clog2(FILL_N + 1);
  localparam int NBR_W  = $clog2(FILL_M + 1);

  // Stimulus/expectation table: one row per line, up to four blocks each.
  localparam int NLINES = 5;
  localparam int NB   [NLINES]    = '{3, 2, 2, 1, 3};
  localparam int LEN  [NLINES][4] = '{'{4, 5, 3, 0}, '{10, 6, 0, 0}, '{6, 12, 0, 0},
                                      '{16, 0, 0, 0}, '{2, 2, 20, 0}};
  localparam int BR   [NLINES][4] = '{'{1, 1, 1, 0}, '{0, 0, 0, 0}, '{1, 1, 0, 0},
                                      '{1, 0, 0, 0}, '{1, 1, 0, 0}};
  localparam int TK   [NLINES][4] = '{'{1, 0, 1, 0}, '{0, 0, 0, 0}, '{1, 1, 0, 0},
                                      '{0, 0, 0, 0}, '{1, 1, 0, 0}};
  localparam int ELEN [NLINES]    = '{12, 16, 16, 16, 16};
  localparam int ENBR [NLINES]    = '{3, 0, 1, 1, 2};
  localparam int EFL  [NLINES]    = '{5, 0, 1, 0, 3};
  localparam int EMK  [NLINES]    = '{3, 0, 0, 0, 1};
  localparam int EBX  [NLINES]    = '{1, 0, 0, 1, 0};
  localparam string RQ_EXIT [NLINES] = '{"R5", "R9", "R4", "R5", "R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic busy, blk_ready, line_valid;
  logic abort = 1'b0;
  logic blk_valid = 1'b0;
  logic [ADDR_W-1:0] blk_addr = '0;
  logic [LEN_W-1:0] blk_len = '0;
  logic blk_has_br = 1'b0;
  logic blk_taken = 1'b0;
  logic [ADDR_W-1:0] blk_target = '0;
  logic [ADDR_W-1:0] blk_fallthru = '0;
  logic line_ready = 1'b0;
  logic [ADDR_W-1:0] line_tag, line_target, line_fallthru;
  logic [CNT_W-1:0] line_len;
  logic [NBR_W-1:0] line_nbr;
  logic [FILL_M-1:0] line_flags, line_mask;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  trace_line_fill #(
    .ADDR_W (ADDR_W), .FILL_N (FILL_N), .FILL_M (FILL_M),
    .LEN_W (LEN_W), .INSTR_BYTES (IB)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .miss_valid (miss_valid), .miss_addr (miss_addr),
    .busy (busy), .abort (abort), .blk_valid (blk_valid), .blk_ready (blk_ready),
    .blk_addr (blk_addr), .blk_len (blk_len), .blk_has_br (blk_has_br),
    .blk_taken (blk_taken), .blk_target (blk_target), .blk_fallthru (blk_fallthru),
    .line_valid (line_valid), .line_ready (line_ready), .line_tag (line_tag),
    .line_len (line_len), .line_nbr (line_nbr), .line_flags (line_flags),
    .line_mask (line_mask), .line_target (line_target), .line_fallthru (line_fallthru)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic start_fill(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic send_blk(input logic [ADDR_W-1:0] a, input int len, input int br,
                          input int tk);
    @(negedge clk);
    blk_valid    = 1'b1;
    blk_addr     = a;
    blk_len      = LEN_W'(len);
    blk_has_br   = (br != 0);
    blk_taken    = (tk != 0);
    blk_target   = a + 32'h80;
    blk_fallthru = a + 32'(len * IB);
    while (!blk_ready) @(negedge clk);
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  task automatic wait_line();
    while (!line_valid) @(negedge clk);
  endtask

  task automatic accept_line();
    line_ready = 1'b1;
    @(negedge clk);
    line_ready = 1'b0;
    chk("R10", "busy after accept", 32'(busy), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset busy", 32'(busy), 32'd0);
    chk("R2", "reset blk_ready", 32'(blk_ready), 32'd0);
    chk("R10", "reset line_valid", 32'(line_valid), 32'd0);

    // Table walk: R3 length, R6 flags, R7 mask, R4/R5/R8/R9 exits.
    for (int ln = 0; ln < NLINES; ln++) begin
      logic [ADDR_W-1:0] tag, a, lastaddr, et, ef;
      int sum, prev, lastlen;
      tag = 32'h1000 * 32'(ln + 1);
      start_fill(tag);
      chk("R1", "busy after miss", 32'(busy), 32'd1);
      sum = 0; prev = 0; lastaddr = tag; lastlen = 0;
      for (int k = 0; k < NB[ln]; k++) begin
        a = tag + 32'h100 * 32'(k);
        send_blk(a, LEN[ln][k], BR[ln][k], TK[ln][k]);
        prev = sum;
        sum += LEN[ln][k];
        lastaddr = a;
        lastlen = LEN[ln][k];
      end
      wait_line();
      if (EBX[ln] != 0) begin
        et = lastaddr + 32'h80;
        ef = lastaddr + 32'(lastlen * IB);
      end else begin
        et = lastaddr + 32'((ELEN[ln] - prev) * IB);
        ef = et;
      end
      chk("R1", "tag", line_tag, tag);
      chk("R3", "line_len", 32'(line_len), 32'(ELEN[ln]));
      chk((ln == 2 || ln == 4) ? "R8" : "R5", "line_nbr", 32'(line_nbr), 32'(ENBR[ln]));
      chk("R6", "line_flags", 32'(line_flags), 32'(EFL[ln]));
      chk("R7", "line_mask", 32'(line_mask), 32'(EMK[ln]));
      chk(RQ_EXIT[ln], "line_target", line_target, et);
      chk(RQ_EXIT[ln], "line_fallthru", line_fallthru, ef);
      accept_line();
    end

    // Directed: a miss while busy is ignored; line held under back-pressure.
    begin
      logic [ADDR_W-1:0] t0;
      start_fill(32'hA000);
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = 32'hB000;
      @(negedge clk);
      miss_valid = 1'b0;
      send_blk(32'hA000, 16, 0, 0);
      wait_line();
      chk("R1", "tag after miss while busy", line_tag, 32'hA000);
      t0 = line_target;
      repeat (3) @(negedge clk);
      chk("R10", "line_valid under stall", 32'(line_valid), 32'd1);
      chk("R10", "target under stall", line_target, t0);
      chk("R9", "sequential exit at exact limit", line_target, 32'hA040);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R11", "abort ignored while line pending", 32'(line_valid), 32'd1);
      chk("R11", "len kept after ignored abort", 32'(line_len), 32'd16);
      accept_line();
    end

    // Directed: abort mid-fill drops the partial line, next fill is clean.
    start_fill(32'hC000);
    send_blk(32'hC000, 3, 1, 1);
    @(negedge clk);
    abort = 1'b1;
    #1;
    chk("R2", "blk_ready while abort", 32'(blk_ready), 32'd0);
    @(negedge clk);
    abort = 1'b0;
    chk("R11", "busy after abort", 32'(busy), 32'd0);
    chk("R11", "no line after abort", 32'(line_valid), 32'd0);
    start_fill(32'hD000);
    send_blk(32'hD000, 16, 0, 0);
    wait_line();
    chk("R11", "len after abort refill", 32'(line_len), 32'd16);
    chk("R11", "nbr after abort refill", 32'(line_nbr), 32'd0);
    chk("R11", "flags after abort refill", 32'(line_flags), 32'd0);
    chk("R1", "tag after abort refill", line_tag, 32'hD000);
    accept_line();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule